// File: doc/BRIEF.md
# Polyphase Decimate-by-Four Low-Pass Filter

This block lowers the sample rate of a signed data stream by an integer factor while applying an 8-tap low-pass response. It is built in polyphase form. The prototype response is split into one short sub-filter per arrival slot. A round-robin selector hands each accepted sample to its slot, and a single 2-tap multiply-add datapath is shared across all slots. The coefficient pair that datapath uses is chosen on every clock from the slot that owns the incoming sample. The block never computes the outputs that a filter-then-discard design would throw away.

Each slot keeps a short private history of the samples it has received. A group accumulator is reloaded by the first sample of each group and adds the partial result of every slot. On the last sample of the group, the accumulated sum is rounded and clamped to the output width and presented with a one-cycle valid strobe. Products and partial sums keep full precision. The only point where precision is reduced is the final rounding and clamping.

The coefficients are a fixed parameter vector. Tap k sits at bits [k*CW +: CW] and multiplies the sample that arrived k accepted samples before the newest one.

Top module: `pf_decim`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0, out_data is 0, the slot selector points at slot 0, and every slot history and the accumulator read as zero. Samples accepted before a reset therefore contribute nothing afterwards.
- R2: Accepted samples (in_valid high at a rising clock edge) are assigned to slots 0, 1, …, M-1 in turn, wrapping after slot M-1, with the first sample after reset going to slot 0. A clock with in_valid low does not advance the selector.
- R3: out_valid is high for exactly one clock, in the cycle that follows the rising edge that accepted every M-th sample since reset (the 4th, 8th, … for M=4). It is low in every other cycle.
- R4: With x[n] as the sample that completes a group, the output equals the rounded and clamped value of the sum over k = 0..7 of h[k]·x[n-k]. Samples before reset count as zero.
- R5: Idle clocks inserted anywhere between accepted samples change neither the output values nor the grouping.
- R6: Rounding adds 2^(SHIFT-1) to the full-precision sum and then shifts it arithmetically right by SHIFT bits, which rounds halves toward positive infinity.
- R7: A rounded result above 2^(OW-1)-1 is output as 2^(OW-1)-1, and one below -2^(OW-1) is output as -2^(OW-1).
- R8: out_data holds its last value in every cycle where out_valid is low.
- R9: Per-slot partial sums and the running group sum are never truncated or wrapped. Full-scale alternating inputs whose partial sums exceed the output range still produce the exact rounded total.
- R10: A reset applied in the middle of a group discards that partial group. The next M accepted samples form a complete group that starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Qualifies in_data on this clock |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-clock strobe marking a new decimated sample |
| out_data | output | OW | Signed rounded and clamped filter output |

## Verification
The bench builds the block with M=4, two taps per slot, 16-bit samples, coefficients and output, and SHIFT=15, as the default does. It overrides the coefficient vector with eight unequal values, two of them negative, whose DC gain is above one. Because every coefficient is distinct, a wrong slot-to-coefficient mapping or a swapped history tap shows up as a wrong value. The gain above one means full-scale constant input drives the result past both clamp limits. Small inputs leave fractional remainders that exercise the rounding of both positive and negative sums.

// File: rtl/pf_decim_pkg.sv
package pf_decim_pkg;

  // Default prototype: symmetric 8-tap low-pass, Q1.15, tap 0 in the low bits.
  localparam int DEF_TAPS = 8;
  localparam int DEF_CW   = 16;
  localparam logic [DEF_TAPS*DEF_CW-1:0] DEF_COEFS = {
    -16'sd600, 16'sd1800, 16'sd7200, 16'sd12000,
    16'sd12000, 16'sd7200, 16'sd1800, -16'sd600
  };

endpackage

// File: rtl/pf_commutator.sv
module pf_commutator #(
  parameter int M  = 4,
  parameter int PW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] phase,
  output logic          first,
  output logic          last
);
  localparam logic [PW-1:0] LAST_PH = PW'(M - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (adv) begin
      if (phase_q == LAST_PH) phase_d = '0;
      else                    phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
  assign first = (phase_q == '0);
  assign last  = (phase_q == LAST_PH);
endmodule

// File: rtl/pf_phase_hist.sv
module pf_phase_hist #(
  parameter int M   = 4,
  parameter int TPP = 2,
  parameter int DW  = 16,
  parameter int PW  = $clog2(M)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [PW-1:0]        phase,
  input  logic signed [DW-1:0] din,
  output logic [TPP*DW-1:0]    taps
);
  generate
    if (TPP > 1) begin : g_hist
      localparam int HD = TPP - 1;
      logic signed [DW-1:0] hist_q [M][HD];
      logic signed [DW-1:0] hist_d [M][HD];

      always_comb begin
        hist_d = hist_q;
        if (en) begin
          for (int j = HD - 1; j > 0; j--) hist_d[phase][j] = hist_q[phase][j-1];
          hist_d[phase][0] = din;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int p = 0; p < M; p++)
            for (int j = 0; j < HD; j++) hist_q[p][j] <= '0;
        end else begin
          hist_q <= hist_d;
        end
      end

      always_comb begin
        taps[DW-1:0] = din;
        for (int j = 1; j < TPP; j++) taps[j*DW +: DW] = hist_q[phase][j-1];
      end
    end else begin : g_nohist
      assign taps = din;
    end
  endgenerate
endmodule

// File: rtl/pf_mac.sv
module pf_mac #(
  parameter int M   = 4,
  parameter int TPP = 2,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int PW  = $clog2(M),
  parameter int SW  = DW + CW + $clog2(TPP),
  parameter logic [M*TPP*CW-1:0] COEF_VEC = '0
) (
  input  logic [PW-1:0]        phase,
  input  logic [TPP*DW-1:0]    taps,
  output logic signed [SW-1:0] sum
);
  localparam int PRW = DW + CW;

  logic signed [CW-1:0]  coef [TPP];
  logic signed [PRW-1:0] prod [TPP];

  // Slot p holds arrival offset M-1-p inside its group; history j is j groups older.
  generate
    for (genvar j = 0; j < TPP; j++) begin : g_tap
      always_comb begin
        coef[j] = COEF_VEC[(j*M + (M - 1) - int'(phase))*CW +: CW];
        prod[j] = $signed(taps[j*DW +: DW]) * coef[j];
      end
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int j = 0; j < TPP; j++) sum = sum + SW'(prod[j]);
  end
endmodule

// File: rtl/pf_out_stage.sv
module pf_out_stage #(
  parameter int SW    = 33,
  parameter int AW    = 35,
  parameter int OW    = 16,
  parameter int SHIFT = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic                 last,
  input  logic signed [SW-1:0] term,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int RW = AW + 1;
  localparam logic signed [RW-1:0] RND   = (RW'(1) << SHIFT) >> 1;
  localparam logic signed [OW-1:0] O_MAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] O_MIN = {1'b1, {(OW-1){1'b0}}};

  logic signed [AW-1:0] acc_q, acc_d, acc_base;
  logic signed [RW-1:0] biased, shifted;
  logic [RW-OW:0]       top;
  logic                 fits;
  logic signed [OW-1:0] res;
  logic                 vld_q;
  logic signed [OW-1:0] dat_q;

  always_comb begin
    acc_base = first ? '0 : acc_q;
    acc_d    = acc_base + {{(AW-SW){term[SW-1]}}, term};
    biased   = {acc_d[AW-1], acc_d} + RND;
    shifted  = biased >>> SHIFT;
    top      = shifted[RW-1:OW-1];
    fits     = (&top) | ~(|top);
    res      = fits ? shifted[OW-1:0] : (shifted[RW-1] ? O_MIN : O_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= en & last;
      if (en)        acc_q <= acc_d;
      if (en & last) dat_q <= res;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/pf_decim.sv
module pf_decim #(
  parameter int M     = 4,
  parameter int TPP   = 2,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 16,
  parameter int SHIFT = 15,
  parameter logic [M*TPP*CW-1:0] COEF_VEC = pf_decim_pkg::DEF_COEFS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int TAPS = M * TPP;
  localparam int PW   = $clog2(M);
  localparam int SW   = DW + CW + $clog2(TPP);
  localparam int AW   = DW + CW + $clog2(TAPS);

  logic [PW-1:0]        phase;
  logic                 first, last;
  logic [TPP*DW-1:0]    taps;
  logic signed [SW-1:0] term;

  pf_commutator #(.M(M), .PW(PW)) u_comm (
    .clk(clk), .rst_n(rst_n), .adv(in_valid),
    .phase(phase), .first(first), .last(last)
  );

  pf_phase_hist #(.M(M), .TPP(TPP), .DW(DW), .PW(PW)) u_hist (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .phase(phase),
    .din(in_data), .taps(taps)
  );

  pf_mac #(.M(M), .TPP(TPP), .DW(DW), .CW(CW), .PW(PW), .SW(SW),
           .COEF_VEC(COEF_VEC)) u_mac (
    .phase(phase), .taps(taps), .sum(term)
  );

  pf_out_stage #(.SW(SW), .AW(AW), .OW(OW), .SHIFT(SHIFT)) u_out (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .first(first), .last(last),
    .term(term), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/pf_decim_checks.sv
module pf_decim_checks #(
  parameter int M  = 4,
  parameter int OW = 16,
  parameter int PW = $clog2(M)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [PW-1:0]        phase,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_data
);
  localparam logic [PW-1:0] LAST_PH = PW'(M - 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (!out_valid && phase == '0 && out_data == '0)
        else $error("reset state not clear");
    end
  end

  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase != LAST_PH) |=> phase == $past(phase) + 1'b1);

  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase == LAST_PH) |=> phase == '0);

  p_pulse_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase == LAST_PH) |=> out_valid);

  p_pulse_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && phase == LAST_PH) |=> !out_valid);

  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind pf_decim pf_decim_checks #(.M(M), .OW(OW), .PW($clog2(M))) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase(phase),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_pf_decim.sv
module test_pf_decim;
  localparam int CLK_PERIOD = 10;
  localparam int M = 4, TPP = 2, TAPS = M * TPP;
  localparam int DW = 16, CW = 16, OW = 16, SHIFT = 15;
  localparam int BC [TAPS] = '{12000, -3000, 9000, 15000, 7000, -8000, 11000, 4000};

  function automatic logic [TAPS*CW-1:0] pack_coefs();
    logic [TAPS*CW-1:0] v;
    for (int k = 0; k < TAPS; k++) v[k*CW +: CW] = CW'(BC[k]);
    return v;
  endfunction
  localparam logic [TAPS*CW-1:0] BCV = pack_coefs();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  pf_decim #(.M(M), .TPP(TPP), .DW(DW), .CW(CW), .OW(OW), .SHIFT(SHIFT),
             .COEF_VEC(BCV)) i_pf_decim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { longint val; int due; string tag; } exp_t;
  exp_t   sbq[$];
  longint hist_m [TAPS];
  int     nsamp = 0;
  int     cyc = 0;
  int     checks = 0;
  int     errors = 0;
  string  tag = "R4";
  logic signed [OW-1:0] last_out = '0;
  bit     done = 0;
  int unsigned lf = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint model_out();
    longint s = 0;
    longint r;
    for (int k = 0; k < TAPS; k++) s += longint'(BC[k]) * hist_m[k];
    r = (s + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
    if (r > (longint'(1) <<< (OW - 1)) - 1) r = (longint'(1) <<< (OW - 1)) - 1;
    if (r < -(longint'(1) <<< (OW - 1)))    r = -(longint'(1) <<< (OW - 1));
    return r;
  endfunction

  task automatic send(input int x);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(x);
    for (int k = TAPS - 1; k > 0; k--) hist_m[k] = hist_m[k-1];
    hist_m[0] = x;
    nsamp++;
    if (nsamp % M == 0) begin
      e.val = model_out(); e.due = cyc + 1; e.tag = tag;
      sbq.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    sbq.delete();
    for (int k = 0; k < TAPS; k++) hist_m[k] = 0;
    nsamp = 0;
    last_out = '0;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1: in reset out_valid=%0b out_data=%0d expected 0 0", out_valid, out_data);
    end
    rst_n = 1'b1;
  endtask

  function automatic int rnd_full();
    lf = lf * 32'd1103515245 + 32'd12345;
    return int'((lf >> 16) & 32'hFFFF) - 32768;
  endfunction

  function automatic int rnd_small();
    lf = lf * 32'd1103515245 + 32'd12345;
    return int'((lf >> 16) % 7) - 3;
  endfunction

  // Scoreboard monitor
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R3: unexpected out_valid at cycle %0d, actual 1 expected 0", cyc);
        end else begin
          e = sbq.pop_front();
          if (e.due != cyc) begin
            errors++;
            $display("FAIL R3: pulse at cycle %0d expected at cycle %0d", cyc, e.due);
          end
          checks++;
          if (longint'(out_data) != e.val) begin
            errors++;
            $display("FAIL %s: out_data=%0d expected %0d", e.tag, out_data, e.val);
          end
        end
        last_out = out_data;
      end else begin
        if (sbq.size() > 0 && sbq[0].due <= cyc) begin
          e = sbq.pop_front();
          errors++;
          checks++;
          $display("FAIL R3: missing pulse at cycle %0d, actual 0 expected 1 (value %0d)", cyc, e.val);
        end
        checks++;
        if (out_data !== last_out) begin
          errors++;
          $display("FAIL R8: out_data=%0d expected held %0d", out_data, last_out);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) hist_m[k] = 0;
    // R1: reset state
    do_reset();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1: after reset out_valid=%0b out_data=%0d expected 0 0", out_valid, out_data);
    end

    // R4: impulse shows each coefficient through its slot and history tap
    tag = "R4";
    send(32767);
    for (int i = 0; i < 11; i++) send(0);
    send(0); send(0); send(0); send(16384);
    for (int i = 0; i < 8; i++) send(0);
    idle(2);

    // R2: ramp streamed back-to-back checks round-robin ordering
    tag = "R2";
    for (int i = 0; i < 24; i++) send(i * 500 - 6000);
    idle(2);

    // R5: idle clocks sprinkled between samples
    tag = "R5";
    for (int i = 0; i < 24; i++) begin
      send(rnd_full() / 2);
      if (i % 3 == 1) idle(i % 4 + 1);
    end
    idle(3);

    // R6: small inputs leave fractional remainders of both signs
    tag = "R6";
    for (int i = 0; i < 64; i++) send(rnd_small());
    idle(2);

    // R7: full-scale constants exceed both clamp limits
    tag = "R7";
    for (int i = 0; i < 12; i++) send(32767);
    for (int i = 0; i < 12; i++) send(-32768);
    idle(2);

    // R9: alternating extremes give partial sums far outside the output range
    tag = "R9";
    for (int i = 0; i < 16; i++) send((i % 2 == 0) ? 32767 : -32768);
    for (int i = 0; i < 16; i++) send((i % 2 == 0) ? -32768 : 32767);
    idle(2);

    // R10: reset in the middle of a group, then a fresh group
    send(20000); send(-15000); send(9000);
    do_reset();
    tag = "R10";
    for (int i = 0; i < 12; i++) send(3000 * (i + 1) - 20000);
    idle(2);

    // R4: long pseudo-random run
    tag = "R4";
    for (int i = 0; i < 400; i++) send(rnd_full());
    idle(4);

    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d outputs missing, expected 0", sbq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule